// File: doc/BRIEF.md
# Masked Pattern Match Trigger

This block watches a wide monitored data bus and compares each valid sample against two independent programmable patterns. Each pattern has a value and a mask, and each is split into 32-bit words. The trigger pattern drives a single-cycle cross-trigger pulse. The data pattern drives its own single-cycle hit pulse. That hit can also raise a timestamp request. The data pattern compares in one of two ways. In value mode it compares the sample itself. In toggle mode it compares the bits that changed since the previous valid sample.

All value words, mask words and a small control word are written and read through a simple register port. The address is split into a 3-bit bank field (upper bits) and a word index (lower bits). The state machine is a two-state sample-history tracker:

- `HIST_EMPTY`: no valid sample has been seen since reset. This is the reset state.
- `HIST_FULL`: the previous sample is held.
- The transition `first_sample` moves from `HIST_EMPTY` to `HIST_FULL` on the first valid sample.
- `HIST_FULL` loops on itself, and only reset leaves it.

Top module: `pattern_match_trigger`

## Requirements
- R1: Reset clears every value, mask and control register, so they read 0. While reset is held, `trig_hit`, `patt_hit` and `ts_req` are 0.
- R2: A write with `reg_wr_en` high stores `reg_wdata` at `reg_addr`. `reg_rdata` returns the addressed register one cycle after the address is presented.
  - The bank field is `reg_addr[5:3]`: 0 = trigger value, 1 = trigger mask, 2 = data value, 3 = data mask, 4 = control.
  - The word index is `reg_addr[2:0]`; word k covers data bits [32k+31:32k].
  - The control word sits at bank 4, index 0. Only its bits [2:0] are stored and read back: bit 0 = toggle mode, bit 1 = data timestamp enable, bit 2 = trigger timestamp enable.
- R3: Mask polarity.
  - A mask bit of 1 compares the corresponding data bit.
  - A mask bit of 0 always matches.
  - A pattern whose mask is all zero matches every valid sample.
- R4: `trig_hit` is high for exactly the cycle after an edge on which `mon_valid` was high and `mon_data` matched the trigger value under the trigger mask. It is never high after a cycle with `mon_valid` low.
- R5: With control bit 0 clear, `patt_hit` pulses the cycle after a valid sample whose literal bits match the data value under the data mask.
- R6: With control bit 0 set, the compared quantity is the sample XOR the previous valid sample. Samples taken while `mon_valid` is low do not update the previous sample.
- R7: In toggle mode, the first valid sample after reset produces no `patt_hit`, even when the mask is all zero.
- R8: `ts_req` pulses in the same cycle as the hits. It is high exactly when `patt_hit` is high with control bit 1 set, or `trig_hit` is high with control bit 2 set.
- R9: Writes to bank 4 at a nonzero index, or to banks 5 to 7, change no register. Reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_valid | input | 1 | Monitored sample is valid this cycle |
| mon_data | input | 256 | Monitored data sample |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address: bank[5:3], word index[2:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| trig_hit | output | 1 | Trigger pattern match pulse |
| patt_hit | output | 1 | Data pattern match pulse |
| ts_req | output | 1 | Timestamp request pulse |

## Verification
The hardest situation to reach from the ports is the toggle-mode history. Its outcome depends on every valid sample since reset, and invalid cycles must be skipped.

The stimulus resets the block, enables toggle mode with the register port alone, and confirms that the first valid sample is refused. It then flips a single masked bit between two valid samples and repeats a sample to see the hit vanish. Finally it inserts an invalid cycle carrying different data, to prove that invalid cycles leave the history untouched.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    localparam int BANK_W = 3;

    typedef enum logic [BANK_W-1:0] {
        BANK_TRIG_VAL = 3'd0,
        BANK_TRIG_MSK = 3'd1,
        BANK_DATA_VAL = 3'd2,
        BANK_DATA_MSK = 3'd3,
        BANK_CTRL     = 3'd4
    } bank_e;

    localparam int CTRL_W       = 3;
    localparam int CTRL_TOGGLE  = 0;
    localparam int CTRL_DATA_TS = 1;
    localparam int CTRL_TRIG_TS = 2;

    typedef enum logic {
        HIST_EMPTY = 1'b0,
        HIST_FULL  = 1'b1
    } hist_state_e;

endpackage

// File: rtl/pmt_regbank.sv
module pmt_regbank #(
    parameter int NWORDS = 8,
    parameter int WORD_W = 32,
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int FULL_W = NWORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_msk,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [FULL_W-1:0] val_o,
    output logic [FULL_W-1:0] msk_o
);

    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_o[k*WORD_W +: WORD_W] <= '0;
                msk_o[k*WORD_W +: WORD_W] <= '0;
            end else if (sel) begin
                if (wr_msk) begin
                    msk_o[k*WORD_W +: WORD_W] <= wdata;
                end else begin
                    val_o[k*WORD_W +: WORD_W] <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/pmt_masked_cmp.sv
module pmt_masked_cmp #(
    parameter int NWORDS = 8,
    parameter int WORD_W = 32,
    localparam int FULL_W = NWORDS * WORD_W
) (
    input  logic [FULL_W-1:0] cmp_i,
    input  logic [FULL_W-1:0] val_i,
    input  logic [FULL_W-1:0] msk_i,
    output logic              hit_o
);

    logic [NWORDS-1:0] word_ok;

    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        logic [WORD_W-1:0] diff;
        assign diff       = (cmp_i[k*WORD_W +: WORD_W] ^ val_i[k*WORD_W +: WORD_W])
                          & msk_i[k*WORD_W +: WORD_W];
        assign word_ok[k] = (diff == '0);
    end

    assign hit_o = &word_ok;

endmodule

// File: rtl/pmt_sample_hist.sv
module pmt_sample_hist
    import pmt_pkg::*;
#(
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic [DATA_W-1:0] prev_o,
    output logic              hist_ok_o
);

    hist_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HIST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: first_sample moves EMPTY -> FULL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HIST_EMPTY: if (smp_valid) state_d = HIST_FULL;
            HIST_FULL:  state_d = HIST_FULL;
            default:    state_d = HIST_EMPTY;
        endcase
    end

    // held sample follows every valid sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_o <= '0;
        end else if (smp_valid) begin
            prev_o <= smp_data;
        end
    end

    assign hist_ok_o = (state_q == HIST_FULL);

endmodule

// File: rtl/pattern_match_trigger.sv
module pattern_match_trigger
    import pmt_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int WORD_W = 32,
    localparam int NWORDS = DATA_W / WORD_W,
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int ADDR_W = BANK_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_valid,
    input  logic [DATA_W-1:0] mon_data,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              trig_hit,
    output logic              patt_hit,
    output logic              ts_req
);

    // address decode
    logic [BANK_W-1:0] bank;
    logic [IDX_W-1:0]  idx;
    assign bank = reg_addr[ADDR_W-1 -: BANK_W];
    assign idx  = reg_addr[IDX_W-1:0];

    logic trig_we, data_we, ctrl_we;
    assign trig_we = reg_wr_en && ((bank == BANK_TRIG_VAL) || (bank == BANK_TRIG_MSK));
    assign data_we = reg_wr_en && ((bank == BANK_DATA_VAL) || (bank == BANK_DATA_MSK));
    assign ctrl_we = reg_wr_en && (bank == BANK_CTRL) && (idx == '0);

    // pattern storage
    logic [DATA_W-1:0] trig_val, trig_msk, data_val, data_msk;

    pmt_regbank #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_trig_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (trig_we),
        .wr_msk (bank == BANK_TRIG_MSK),
        .wr_idx (idx),
        .wdata  (reg_wdata),
        .val_o  (trig_val),
        .msk_o  (trig_msk)
    );

    pmt_regbank #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_data_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (data_we),
        .wr_msk (bank == BANK_DATA_MSK),
        .wr_idx (idx),
        .wdata  (reg_wdata),
        .val_o  (data_val),
        .msk_o  (data_msk)
    );

    logic [CTRL_W-1:0] ctrl_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= reg_wdata[CTRL_W-1:0];
        end
    end

    // read path
    logic [WORD_W-1:0] rd_d;
    always_comb begin
        rd_d = '0;
        case (bank)
            BANK_TRIG_VAL: rd_d = trig_val[idx*WORD_W +: WORD_W];
            BANK_TRIG_MSK: rd_d = trig_msk[idx*WORD_W +: WORD_W];
            BANK_DATA_VAL: rd_d = data_val[idx*WORD_W +: WORD_W];
            BANK_DATA_MSK: rd_d = data_msk[idx*WORD_W +: WORD_W];
            BANK_CTRL:     if (idx == '0) rd_d[CTRL_W-1:0] = ctrl_q;
            default:       rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else begin
            reg_rdata <= rd_d;
        end
    end

    // sample history
    logic [DATA_W-1:0] prev_smp;
    logic              hist_ok;

    pmt_sample_hist #(.DATA_W(DATA_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (mon_valid),
        .smp_data  (mon_data),
        .prev_o    (prev_smp),
        .hist_ok_o (hist_ok)
    );

    // comparators
    logic toggle_mode;
    logic [DATA_W-1:0] data_cmp;
    assign toggle_mode = ctrl_q[CTRL_TOGGLE];
    assign data_cmp    = toggle_mode ? (mon_data ^ prev_smp) : mon_data;

    logic trig_eq, data_eq;

    pmt_masked_cmp #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_trig_cmp (
        .cmp_i (mon_data),
        .val_i (trig_val),
        .msk_i (trig_msk),
        .hit_o (trig_eq)
    );

    pmt_masked_cmp #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_data_cmp (
        .cmp_i (data_cmp),
        .val_i (data_val),
        .msk_i (data_msk),
        .hit_o (data_eq)
    );

    logic trig_fire, data_fire, ts_fire;
    assign trig_fire = mon_valid && trig_eq;
    assign data_fire = mon_valid && data_eq && (!toggle_mode || hist_ok);
    assign ts_fire   = (data_fire && ctrl_q[CTRL_DATA_TS])
                    || (trig_fire && ctrl_q[CTRL_TRIG_TS]);

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_hit <= 1'b0;
            patt_hit <= 1'b0;
            ts_req   <= 1'b0;
        end else begin
            trig_hit <= trig_fire;
            patt_hit <= data_fire;
            ts_req   <= ts_fire;
        end
    end

endmodule

// File: rtl/pmt_checker.sv
module pmt_checker #(
    parameter int DATA_W = 256,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mon_valid,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WORD_W-1:0] reg_rdata,
    input logic [DATA_W-1:0] trig_msk,
    input logic [2:0]        ctrl,
    input logic              trig_hit,
    input logic              patt_hit,
    input logic              ts_req
);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!trig_hit && !patt_hit && !ts_req)
                else $error("outputs active during reset");
        end
    end

    p_open_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mon_valid) && ($past(trig_msk) == '0)) |-> trig_hit);

    p_trig_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |-> $past(mon_valid));

    p_patt_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        patt_hit |-> $past(mon_valid));

    p_ts_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ts_req |-> (trig_hit || patt_hit));

    p_ts_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (patt_hit && $past(ctrl[1])) |-> ts_req);

    p_ts_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && $past(ctrl[2])) |-> ts_req);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_addr[ADDR_W-1 -: 3]) > 3'd4) |-> (reg_rdata == '0));

endmodule

bind pattern_match_trigger pmt_checker #(
    .DATA_W (DATA_W),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) u_pmt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_valid (mon_valid),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .trig_msk  (trig_msk),
    .ctrl      (ctrl_q),
    .trig_hit  (trig_hit),
    .patt_hit  (patt_hit),
    .ts_req    (ts_req)
);

// File: tb/test_pattern_match_trigger.sv
`timescale 1ns/1ps
module test_pattern_match_trigger;

    localparam int DW = 256;
    localparam int WW = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mon_valid = 1'b0;
    logic [DW-1:0] mon_data = '0;
    logic          reg_wr_en = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [WW-1:0] reg_wdata = '0;
    logic [WW-1:0] reg_rdata;
    logic          trig_hit, patt_hit, ts_req;

    pattern_match_trigger i_pattern_match_trigger (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_valid (mon_valid),
        .mon_data  (mon_data),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .trig_hit  (trig_hit),
        .patt_hit  (patt_hit),
        .ts_req    (ts_req)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    // reference model state
    logic [DW-1:0] m_tv, m_tm, m_dv, m_dm, m_prev;
    logic [2:0]    m_ctrl;
    bit            m_have;

    function automatic logic [DW-1:0] put(input logic [DW-1:0] d, input int k, input logic [31:0] v);
        logic [DW-1:0] r = d;
        r[k*32 +: 32] = v;
        return r;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; mon_valid = 1'b0; reg_wr_en = 1'b0;
        m_tv = '0; m_tm = '0; m_dv = '0; m_dm = '0; m_prev = '0; m_ctrl = '0; m_have = 1'b0;
        repeat (2) @(negedge clk);
        total++;
        if ({ts_req, patt_hit, trig_hit} !== 3'b000) begin
            bad++;
            $display("FAIL R1 outputs in reset actual=%b expected=000", {ts_req, patt_hit, trig_hit});
        end
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] bank, input int k, input logic [31:0] v);
        @(negedge clk);
        mon_valid = 1'b0; reg_wr_en = 1'b1;
        reg_addr = {bank, 3'(k)}; reg_wdata = v;
        case (bank)
            3'd0: m_tv = put(m_tv, k, v);
            3'd1: m_tm = put(m_tm, k, v);
            3'd2: m_dv = put(m_dv, k, v);
            3'd3: m_dm = put(m_dm, k, v);
            3'd4: if (k == 0) m_ctrl = v[2:0];
            default: ;
        endcase
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        mon_valid = 1'b0; reg_wr_en = 1'b0; reg_addr = a;
        @(negedge clk);
        total++;
        if (reg_rdata !== exp) begin
            bad++;
            $display("FAIL %s read addr=%h actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic step(input logic v, input logic [DW-1:0] d, input string tag);
        item_t it;
        logic tq, pq;
        logic [DW-1:0] cmpd;
        @(negedge clk);
        reg_wr_en = 1'b0; mon_valid = v; mon_data = d;
        tq   = v && (((d ^ m_tv) & m_tm) == '0);
        cmpd = m_ctrl[0] ? (d ^ m_prev) : d;
        pq   = v && (!m_ctrl[0] || m_have) && (((cmpd ^ m_dv) & m_dm) == '0);
        it.exp = {(pq && m_ctrl[1]) || (tq && m_ctrl[2]), pq, tq};
        it.tag = tag;
        sb_q.push_back(it);
        if (v) begin
            m_prev = d;
            m_have = 1'b1;
        end
    endtask

    // monitor: pops one expected item per sampled edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if ({ts_req, patt_hit, trig_hit} !== it.exp) begin
                    bad++;
                    $display("FAIL %s {ts,patt,trig} actual=%b expected=%b",
                             it.tag, {ts_req, patt_hit, trig_hit}, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog all-reqs actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    logic [DW-1:0] base;

    initial begin
        base = {8{32'h1357_9BDF}};
        do_reset();
        // R1 registers clear after reset
        rd_chk(6'h00, 32'h0, "R1");
        rd_chk(6'h0F, 32'h0, "R1");
        rd_chk(6'h17, 32'h0, "R1");
        rd_chk(6'h1F, 32'h0, "R1");
        rd_chk(6'h20, 32'h0, "R1");

        // R3 all-zero masks match every valid sample; R4 nothing when invalid
        step(1'b1, base, "R3");
        step(1'b1, ~base, "R3");
        step(1'b0, base, "R4");

        // R2 register port
        wr(3'd0, 3, 32'hDEAD_BEEF);
        rd_chk(6'h03, 32'hDEAD_BEEF, "R2");
        wr(3'd3, 7, 32'h0000_FFFF);
        rd_chk(6'h1F, 32'h0000_FFFF, "R2");
        wr(3'd4, 0, 32'h0000_0007);
        rd_chk(6'h20, 32'h0000_0007, "R2");
        wr(3'd4, 0, 32'hFFFF_FFF8);
        rd_chk(6'h20, 32'h0000_0000, "R2");

        // R9 unmapped addresses
        wr(3'd4, 1, 32'h0000_1234);
        wr(3'd6, 0, 32'h0000_5555);
        rd_chk(6'h21, 32'h0, "R9");
        rd_chk(6'h30, 32'h0, "R9");
        rd_chk(6'h20, 32'h0, "R9");
        rd_chk(6'h03, 32'hDEAD_BEEF, "R9");

        // R4 trigger compare on word 3
        wr(3'd1, 3, 32'hFFFF_FFFF);
        step(1'b1, put(base, 3, 32'hDEAD_BEEF), "R4");
        step(1'b1, put(base, 3, 32'hDEAD_BEEE), "R4");
        step(1'b0, put(base, 3, 32'hDEAD_BEEF), "R4");
        // R3 partial mask
        wr(3'd1, 3, 32'h0000_00FF);
        step(1'b1, put(base, 3, 32'h1234_56EF), "R3");
        step(1'b1, put(base, 3, 32'h1234_56EE), "R3");

        // R5 literal data pattern on word 0
        wr(3'd3, 7, 32'h0);
        wr(3'd2, 0, 32'hA5A5_A5A5);
        wr(3'd3, 0, 32'hFFFF_FFFF);
        step(1'b1, put(base, 0, 32'hA5A5_A5A5), "R5");
        step(1'b1, put(base, 0, 32'hA5A5_A5A4), "R5");
        step(1'b1, put(~base, 0, 32'hA5A5_A5A5), "R5");

        // R8 timestamp request enables
        wr(3'd4, 0, 32'h2);
        step(1'b1, put(base, 0, 32'hA5A5_A5A5), "R8");
        step(1'b1, put(put(base, 0, 32'hA5A5_A5A5), 3, 32'h0000_00EF), "R8");
        wr(3'd4, 0, 32'h4);
        step(1'b1, put(base, 0, 32'hA5A5_A5A5), "R8");
        step(1'b1, put(base, 3, 32'h0000_00EF), "R8");
        wr(3'd4, 0, 32'h6);
        step(1'b1, put(base, 3, 32'h0000_00EF), "R8");
        step(1'b1, base, "R8");
        step(1'b0, base, "R8");

        // R7 first sample after reset in toggle mode; R6 toggle compare
        do_reset();
        wr(3'd4, 0, 32'h1);
        step(1'b1, base, "R7");
        step(1'b1, base, "R6");
        wr(3'd2, 1, 32'h0000_0001);
        wr(3'd3, 1, 32'hFFFF_FFFF);
        step(1'b1, base, "R6");
        step(1'b1, put(base, 1, base[63:32] ^ 32'h1), "R6");
        step(1'b1, put(base, 1, base[63:32] ^ 32'h1), "R6");
        step(1'b0, base, "R6");
        step(1'b1, put(base, 1, base[63:32] ^ 32'h1), "R6");
        step(1'b1, base, "R6");
        step(1'b0, base, "R6");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule